// File: doc/BRIEF.md
# Two-Round Key Scheduling Engine

This block turns a secret key of programmable length into a scrambled 256-entry byte permutation, ready for a separate keystream generator. Key bytes are written into an internal bank of byte slots through a valid/ready load port. A start strobe then latches the key length and begins a run. The run first resets the permutation to the identity. It then performs 256 scheduling rounds, two per step. Each round adds the current entry and a cyclically repeating key byte to a running index, and swaps two entries.

Each step evaluates two rounds back to back in one calculation cycle. The second round sees the first round's swap through forwarding, so the result is the same as the one-round-at-a-time schedule. The swaps are committed in the following cycle. Two modulo-length counters select the key bytes for the two rounds through a pair of slot multiplexers, so no division is needed. While a run is in progress, the permutation read port returns zero, so no scrambled state leaves the block.

The load port follows valid/ready rules. A byte is taken on a rising clock edge where both `key_valid` and `key_ready` are high. `key_ready` is low for the whole run, which is the only back-pressure. A source must hold its byte until it sees ready.

Top module: `ksched_dual`

## Requirements
- R1: After reset, `busy` and `done` are 0, `key_ready` is 1, and `perm_data` equals `perm_addr` for every address (identity permutation).
- R2: A key byte is written into slot `key_idx` on an edge where `key_valid` and `key_ready` are both 1. `key_ready` is 0 while `busy` is 1, and a byte offered then has no effect on the resulting permutation.
- R3: `start` while idle begins a run, and `busy` is 1 from the next cycle. `key_len` is sampled at that edge as the key length l. A value of 0 is taken as 1, and a value above 16 is taken as 16.
- R4: At the end of a run, the permutation equals this schedule. S starts as the identity and j starts at 0. For i = 0..255 in order: j = (j + S[i] + K[i mod l]) mod 256, then S[i] and S[j] are swapped. This holds for every l from 1 to 16, including 8, 13 and 15.
- R5: When the second round of a step touches an entry the first round just swapped (j1 = i2, j2 = i1, j2 = j1 or i1 = j1), the result still matches R4.
- R6: `busy` stays high for exactly 257 cycles: one initialising cycle plus two cycles for each of the 128 steps. `done` is 1 for exactly one cycle, the first cycle with `busy` low.
- R7: A `start` during a run is ignored. It neither shortens nor extends the run, and it does not queue a second run.
- R8: While `busy` is 1, `perm_data` is 0 for any `perm_addr`.
- R9: Slots at index l and above have no influence on the result.
- R10: Every run restarts from the identity, so repeating a run with the same key and length gives the same permutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Key byte offered on the load port |
| key_ready | output | 1 | Load port can accept a byte (idle) |
| key_idx | input | 4 | Slot number for the offered key byte |
| key_byte | input | 8 | Key byte value |
| key_len | input | 5 | Key length in bytes, sampled at start |
| start | input | 1 | Begin a scheduling run (ignored when busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the final round |
| perm_addr | input | 8 | Permutation read address |
| perm_data | output | 8 | Permutation entry at `perm_addr`, zero while busy |

## Verification
The two rounds of one step fall in the same calculation cycle. The second round's reads can land on entries that the first round's swap has just changed, and the same entry can also receive several of the four commit writes. The bench provokes every case in the first step with crafted key bytes. K[0]=1 and K[1]=255 give j1 = i2 and j2 = i1. K[0]=1 and K[1]=0 give j2 = j1. K[0]=0 with K[1]=0 or K[1]=255 gives i1 = j1. Each result is judged entry by entry against a behavioural one-round-per-iteration schedule computed in the bench.

// File: rtl/ksd_pkg.sv
package ksd_pkg;
  localparam int BYTE_W    = 8;
  localparam int KEY_SLOTS = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_CALC,
    ST_WRITE
  } ks_state_e;
endpackage

// File: rtl/ksd_modcnt.sv
module ksd_modcnt #(
  parameter int LEN_W  = 5,
  parameter int OFFSET = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  input  logic [LEN_W-1:0] modulus,
  output logic [LEN_W-1:0] value
);
  function automatic logic [LEN_W-1:0] bump(input logic [LEN_W-1:0] v,
                                            input logic [LEN_W-1:0] m);
    logic [LEN_W-1:0] t;
    t = v + 1'b1;
    return (t >= m) ? '0 : t;
  endfunction

  logic [LEN_W-1:0] start_v;

  always_comb begin
    start_v = '0;
    for (int k = 0; k < OFFSET; k++) start_v = bump(start_v, modulus);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (clear)   value <= start_v;
    else if (advance) value <= bump(bump(value, modulus), modulus);
  end
endmodule

// File: rtl/ksd_keymux.sv
module ksd_keymux #(
  parameter int BYTE_W = 8,
  parameter int SLOTS  = 16,
  parameter int SEL_W  = 5
) (
  input  logic [SLOTS-1:0][BYTE_W-1:0] slots,
  input  logic [SEL_W-1:0]             sel,
  output logic [BYTE_W-1:0]            byte_o
);
  always_comb begin
    byte_o = '0;
    for (int e = 0; e < SLOTS; e++)
      if (sel == SEL_W'(e)) byte_o = slots[e];
  end
endmodule

// File: rtl/ksd_permbank.sv
module ksd_permbank #(
  parameter int BYTE_W = 8,
  parameter int N_WR   = 4,
  parameter int N_RD   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        init,
  input  logic [N_WR-1:0]             we,
  input  logic [N_WR-1:0][BYTE_W-1:0] waddr,
  input  logic [N_WR-1:0][BYTE_W-1:0] wdata,
  input  logic [N_RD-1:0][BYTE_W-1:0] raddr,
  output logic [N_RD-1:0][BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << BYTE_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  // Later write ports take priority: they model later swaps of the same step.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= BYTE_W'(e);
    end else if (init) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= BYTE_W'(e);
    end else begin
      for (int p = 0; p < N_WR; p++)
        if (we[p]) mem[waddr[p]] <= wdata[p];
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rdata[r] = mem[raddr[r]];
  end
endmodule

// File: rtl/ksched_dual.sv
module ksched_dual
  import ksd_pkg::*;
#(
  parameter int BYTE_W    = ksd_pkg::BYTE_W,
  parameter int KEY_SLOTS = ksd_pkg::KEY_SLOTS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         key_valid,
  output logic                         key_ready,
  input  logic [$clog2(KEY_SLOTS)-1:0] key_idx,
  input  logic [BYTE_W-1:0]            key_byte,
  input  logic [$clog2(KEY_SLOTS+1)-1:0] key_len,
  input  logic                         start,
  output logic                         busy,
  output logic                         done,
  input  logic [BYTE_W-1:0]            perm_addr,
  output logic [BYTE_W-1:0]            perm_data
);
  localparam int PERM_N = 1 << BYTE_W;
  localparam int LEN_W  = $clog2(KEY_SLOTS + 1);
  localparam int LANES  = 2;
  localparam logic [BYTE_W-1:0] LAST_I = BYTE_W'(PERM_N - 2);

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
    if (v == '0) return LEN_W'(1);
    if (v > LEN_W'(KEY_SLOTS)) return LEN_W'(KEY_SLOTS);
    return v;
  endfunction

  ks_state_e st_q;
  logic [LEN_W-1:0]  len_q;
  logic [BYTE_W-1:0] i_q, j_q;
  logic [BYTE_W-1:0] j1_q, j2_q, a1_q, b1_q, a2_q, b2_q;
  logic [KEY_SLOTS-1:0][BYTE_W-1:0] key_q;
  logic done_q;

  logic [LANES-1:0][LEN_W-1:0]  kidx;
  logic [LANES-1:0][BYTE_W-1:0] kbyte;

  logic [3:0]             we;
  logic [3:0][BYTE_W-1:0] waddr, wdata;
  logic [4:0][BYTE_W-1:0] raddr, rdata;

  logic [BYTE_W-1:0] i2, j1_c, a2_c, j2_c, b2_c;

  // Key index lanes: lane g tracks (i1 + g) mod l.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ksd_modcnt #(.LEN_W(LEN_W), .OFFSET(g)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (st_q == ST_INIT),
      .advance (st_q == ST_WRITE),
      .modulus (len_q),
      .value   (kidx[g])
    );
    ksd_keymux #(.BYTE_W(BYTE_W), .SLOTS(KEY_SLOTS), .SEL_W(LEN_W)) u_mux (
      .slots  (key_q),
      .sel    (kidx[g]),
      .byte_o (kbyte[g])
    );
  end

  // Two chained rounds evaluated in the calculation cycle.
  always_comb begin
    i2       = i_q + 1'b1;
    raddr[0] = i_q;
    j1_c     = j_q + rdata[0] + kbyte[0];
    raddr[1] = j1_c;
    raddr[2] = i2;
    a2_c     = (i2 == j1_c) ? rdata[0] : rdata[2];
    j2_c     = j1_c + a2_c + kbyte[1];
    raddr[3] = j2_c;
    if (j2_c == i_q)       b2_c = rdata[1];
    else if (j2_c == j1_c) b2_c = rdata[0];
    else                   b2_c = rdata[3];
    raddr[4] = perm_addr;
  end

  // Commit of both swaps, ordered so the second round wins on overlap.
  always_comb begin
    we       = {4{st_q == ST_WRITE}};
    waddr[0] = i_q;          wdata[0] = b1_q;
    waddr[1] = j1_q;         wdata[1] = a1_q;
    waddr[2] = i_q + 1'b1;   wdata[2] = b2_q;
    waddr[3] = j2_q;         wdata[3] = a2_q;
  end

  ksd_permbank #(.BYTE_W(BYTE_W), .N_WR(4), .N_RD(5)) u_perm (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (st_q == ST_INIT),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= LEN_W'(1);
      i_q    <= '0;
      j_q    <= '0;
      j1_q   <= '0;
      j2_q   <= '0;
      a1_q   <= '0;
      b1_q   <= '0;
      a2_q   <= '0;
      b2_q   <= '0;
      key_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (key_valid && key_ready) key_q[key_idx] <= key_byte;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            len_q <= clamp_len(key_len);
            st_q  <= ST_INIT;
          end
        end
        ST_INIT: begin
          i_q  <= '0;
          j_q  <= '0;
          st_q <= ST_CALC;
        end
        ST_CALC: begin
          j1_q <= j1_c;
          a1_q <= rdata[0];
          b1_q <= rdata[1];
          j2_q <= j2_c;
          a2_q <= a2_c;
          b2_q <= b2_c;
          st_q <= ST_WRITE;
        end
        ST_WRITE: begin
          j_q <= j2_q;
          i_q <= i_q + BYTE_W'(2);
          if (i_q == LAST_I) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= ST_CALC;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign key_ready = ~busy;
  assign done      = done_q;
  assign perm_data = busy ? '0 : rdata[4];
endmodule

// File: rtl/ksched_dual_chk.sv
module ksched_dual_chk #(
  parameter int BYTE_W = ksd_pkg::BYTE_W
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done
);
  localparam int RUN_CYC = 1 + (1 << BYTE_W);
  localparam int CNT_W   = $clog2(RUN_CYC + 2);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R6
  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CNT_W'(RUN_CYC))); // R7
endmodule

bind ksched_dual ksched_dual_chk u_ksched_dual_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done)
);

// File: tb/test_ksched_dual.sv
module test_ksched_dual;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_valid = 1'b0;
  logic       key_ready;
  logic [3:0] key_idx = '0;
  logic [7:0] key_byte = '0;
  logic [4:0] key_len = 5'd8;
  logic       start = 1'b0;
  logic       busy, done;
  logic [7:0] perm_addr = '0;
  logic [7:0] perm_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] tb_key [16];
  int ref_s [256];

  always #4 clk = ~clk;

  ksched_dual i_ksched_dual (
    .clk (clk), .rst_n (rst_n),
    .key_valid (key_valid), .key_ready (key_ready),
    .key_idx (key_idx), .key_byte (key_byte), .key_len (key_len),
    .start (start), .busy (busy), .done (done),
    .perm_addr (perm_addr), .perm_data (perm_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic load_key();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      key_valid = 1'b1;
      key_idx   = 4'(k);
      key_byte  = tb_key[k];
    end
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic ref_ksa(input int l);
    int j, t;
    for (int k = 0; k < 256; k++) ref_s[k] = k;
    j = 0;
    for (int i = 0; i < 256; i++) begin
      j = (j + ref_s[i] + int'(tb_key[i % l])) % 256;
      t = ref_s[i]; ref_s[i] = ref_s[j]; ref_s[j] = t;
    end
  endtask

  // R6 R7 R8 R2: one run, timed from the start edge
  task automatic run_sched(input int lenval, input bit disturb);
    int busy_cyc, done_at;
    busy_cyc = 0;
    done_at  = 0;
    perm_addr = 8'd77;
    @(negedge clk);
    key_len = 5'(lenval);
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 400; c++) begin
      if (c > 1) @(negedge clk);
      if (done) begin
        done_at = c;
        chk(!busy, "R6 busy low with done", int'(busy), 0);
        break;
      end
      if (busy) busy_cyc++;
      if (c == 3) begin
        chk(perm_data == 8'd0, "R8 output quiet while busy", int'(perm_data), 0);
        chk(!key_ready, "R2 key_ready low while busy", int'(key_ready), 0);
      end
      if (disturb) begin
        if (c == 60) start = 1'b1;
        if (c == 61) start = 1'b0;
        if (c == 80) begin
          key_valid = 1'b1; key_idx = 4'd0; key_byte = ~tb_key[0];
        end
        if (c == 81) key_valid = 1'b0;
      end
    end
    chk(done_at == 258, "R6 done cycle", done_at, 258);
    chk(busy_cyc == 257, "R6 busy length", busy_cyc, 257);
    @(negedge clk);
    chk(!done, "R6 done single pulse", int'(done), 0);
    chk(!busy, "R7 no queued run", int'(busy), 0);
  endtask

  task automatic check_perm(input int l, input string req);
    ref_ksa(l);
    for (int a = 0; a < 256; a++) begin
      perm_addr = 8'(a);
      #1;
      chk(int'(perm_data) == ref_s[a], req, int'(perm_data), ref_s[a]);
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) tb_key[k] = 8'(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(!done, "R1 done", int'(done), 0);
    chk(key_ready, "R1 key_ready", int'(key_ready), 1);
    for (int a = 0; a < 256; a++) begin
      perm_addr = 8'(a);
      #1;
      chk(int'(perm_data) == a, "R1 identity", int'(perm_data), a);
    end

    // R4 R9 sweep over every key length, unused slots filled with other bytes
    for (int l = 1; l <= 16; l++) begin
      for (int k = 0; k < 16; k++) tb_key[k] = 8'((l * 37 + k * 91 + 5) & 255);
      load_key();
      run_sched(l, 1'b0);
      check_perm(l, "R4 R9 length sweep");
    end

    // R5 first-step collisions: {K0,K1} pairs
    for (int v = 0; v < 4; v++) begin
      for (int k = 0; k < 16; k++) tb_key[k] = 8'((k * 53 + 11) & 255);
      case (v)
        0: begin tb_key[0] = 8'd1; tb_key[1] = 8'd255; end
        1: begin tb_key[0] = 8'd1; tb_key[1] = 8'd0;   end
        2: begin tb_key[0] = 8'd0; tb_key[1] = 8'd0;   end
        default: begin tb_key[0] = 8'd0; tb_key[1] = 8'd255; end
      endcase
      load_key();
      run_sched(8, 1'b0);
      check_perm(8, "R5 forwarding collision");
    end

    // R3 length clamp: 0 acts as 1, 20 acts as 16
    for (int k = 0; k < 16; k++) tb_key[k] = 8'((k * 29 + 200) & 255);
    load_key();
    run_sched(0, 1'b0);
    check_perm(1, "R3 clamp zero");
    run_sched(20, 1'b0);
    check_perm(16, "R3 clamp high");

    // R7 R2: start and key write during a run are ignored
    for (int k = 0; k < 16; k++) tb_key[k] = 8'((k * 7 + 3) & 255);
    load_key();
    run_sched(13, 1'b1);
    check_perm(13, "R2 R7 ignored during run");

    // R10 repeat run with same key restarts from identity
    run_sched(13, 1'b0);
    check_perm(13, "R10 rerun");

    summary();
    $finish;
  end
endmodule